// File: doc/BRIEF.md
# Glitch-Free Reference Clock Switchover Controller

This block chooses which of two free-running reference clocks drives a single clock output, and changes that choice on request without ever producing a runt pulse. A switch is started by a qualified rising edge of a manual request. The output is first gated off on a falling edge of the clock currently in use. Only after that clock is confirmed gated is the other clock connected, on one of its own falling edges. Every control bit that moves between the two clock domains passes through a two-flop synchronizer before it gates or selects anything.

If the clock being switched to is not toggling, the controller holds the output low and waits; the switch completes on its own once that clock starts. A pair of missing-edge detectors raises a per-clock flag when a clock stops. Each detector runs on the opposite clock. An active-source flag tells downstream logic which input currently feeds the output.

Top module: `refclk_switch`

## Requirements
- R1: A switch starts only on a rising edge of `switchReq`. Lowering the request never starts a switch, so releasing it leaves the selection where it is.
- R2: The request must be sampled high on 3 consecutive rising edges of the currently active clock, after synchronization. A shorter pulse, such as one covering at most 2 active-clock edges, causes no switch.
- R3: `clkOut` is never driven by both inputs at once. It shows no high pulse shorter than half a period of the clock feeding it.
- R4: The new clock is connected on one of its own falling edges. This happens only after the old clock's enable has been observed low, and from then on `clkOut` follows the new clock's frequency.
- R5: `activeSel` reads 0 when input 0 feeds the output and 1 when input 1 does. It changes when the new clock is connected and keeps its previous value while the output is gated between sources.
- R6: Each later qualified rising edge of the request, after the request has been low, toggles the selection again using the same gate-then-connect order.
- R7: If the target clock is not running, `clkOut` stays low and `activeSel` keeps its old value. The switch completes once the target clock starts toggling.
- R8: `bad0` (or `bad1`) goes to 1 after 4 consecutive cycles of the other clock in which no edge of input 0 (or input 1) is seen through the synchronizer. The flag returns to 0 once edges are seen again.
- R9: While both clocks run, including during a manual switch, `bad0` and `bad1` stay 0.
- R10: While the request stays high after a switch has started, no further switch occurs, however long it is held.
- R11: During and after reset, input 0 is selected and `activeSel` is 0. `clkOut` stays low until the first falling edge of input 0, then follows it. Both bad flags are 0 in reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk0In | input | 1 | Reference clock 0 |
| clk1In | input | 1 | Reference clock 1 |
| rstN | input | 1 | Asynchronous active-low reset |
| switchReq | input | 1 | Manual switch request, asynchronous level |
| clkOut | output | 1 | Selected, glitch-free clock output |
| activeSel | output | 1 | Source now feeding clkOut (0 = clk0In, 1 = clk1In) |
| bad0 | output | 1 | clk0In missing (clk1In domain) |
| bad1 | output | 1 | clk1In missing (clk0In domain) |

## Verification
The bench sends pulses too short to qualify. A design that counted a single sampled high would flip the selection on these glitches. It holds the request high for far longer than one switch needs, which catches a design that keeps toggling or switches back when the request is released. It stops clock 1 before requesting a switch to it. A correct design holds the output low and the flag at 0, while a wrong one either switches to a dead clock at once or never resumes when the clock returns. A runt-pulse monitor on the output, together with edge-rate windows after every switch, exposes any overlap or early connect between the two sources.

// File: rtl/refsw_pkg.sv
`timescale 1ns/1ps
package refsw_pkg;
  localparam int NUM_SRC = 2;

  // strobes from request control to the gating datapath
  typedef struct packed {
    logic [NUM_SRC-1:0] want;   // per source: should be connected
  } refsw_strobe_t;
endpackage

// File: rtl/refsw_ctrl.sv
`timescale 1ns/1ps
module refsw_ctrl
  import refsw_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 3
) (
  input  logic [NUM_SRC-1:0] clkIn,
  input  logic               rstN,
  input  logic               switchReq,
  input  logic [NUM_SRC-1:0] enNow,
  output refsw_strobe_t      strobe
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);

  logic [NUM_SRC-1:0] handTog;
  logic [NUM_SRC-1:0] wantVec;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int J = 1 - i;
    logic [SYNC_STAGES-1:0] reqSh;
    logic [SYNC_STAGES:0]   handSh;
    logic [CW-1:0]          hiCnt;
    logic                   handTogL;
    logic                   wantL;
    logic                   reqLvl;
    logic                   peerFlip;
    logic                   fire;

    assign reqLvl   = reqSh[SYNC_STAGES-1];
    assign peerFlip = handSh[SYNC_STAGES] ^ handSh[SYNC_STAGES-1];
    // only the connected owner may hand off, exactly once per qualified high
    assign fire     = reqLvl && (hiCnt == CW'(QUAL_CYCLES - 1)) && enNow[i] && wantL;

    always_ff @(posedge clkIn[i] or negedge rstN) begin
      if (!rstN) begin
        reqSh    <= '0;
        handSh   <= '0;
        hiCnt    <= '0;
        handTogL <= 1'b0;
        wantL    <= 1'(i == 0);
      end else begin
        reqSh  <= {reqSh[SYNC_STAGES-2:0], switchReq};
        handSh <= {handSh[SYNC_STAGES-1:0], handTog[J]};
        if (!reqLvl)
          hiCnt <= '0;
        else if (hiCnt != CW'(QUAL_CYCLES))
          hiCnt <= hiCnt + 1'b1;
        if (fire) begin
          handTogL <= ~handTogL;
          wantL    <= 1'b0;
        end else if (peerFlip) begin
          wantL    <= 1'b1;
        end
      end
    end

    assign handTog[i] = handTogL;
    assign wantVec[i] = wantL;

    // a handoff needs the request seen high on the previous two edges
    p_held_req_r2: assert property (@(posedge clkIn[i]) disable iff (!rstN)
      (handTogL != $past(handTogL)) |-> ($past(reqLvl, 1) && $past(reqLvl, 2)));
  end

  assign strobe.want = wantVec;
endmodule

// File: rtl/refsw_gate.sv
`timescale 1ns/1ps
module refsw_gate
  import refsw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic [NUM_SRC-1:0] clkIn,
  input  logic               rstN,
  input  refsw_strobe_t      strobe,
  output logic [NUM_SRC-1:0] enNow,
  output logic               clkOut,
  output logic               activeSel
);
  logic [NUM_SRC-1:0] enVec;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
    localparam int J = 1 - i;
    logic [SYNC_STAGES-1:0] peerEnSh;
    logic                   enL;

    // enable moves only on this clock's falling edge, while it is low
    always_ff @(negedge clkIn[i] or negedge rstN) begin
      if (!rstN) begin
        peerEnSh <= '0;
        enL      <= 1'b0;
      end else begin
        peerEnSh <= {peerEnSh[SYNC_STAGES-2:0], enVec[J]};
        enL      <= strobe.want[i] && !peerEnSh[SYNC_STAGES-1];
      end
    end

    assign enVec[i] = enL;

    p_one_src_r3: assert property (@(posedge clkIn[i]) disable iff (!rstN)
      !(enVec[0] && enVec[1]));

    p_break_first_r4: assert property (@(negedge clkIn[i]) disable iff (!rstN)
      $rose(enL) |-> !enVec[J]);
  end

  // remembers that source 1 was last connected, so the flag holds in the gap
  logic wasOn1;
  always_ff @(negedge clkIn[1] or negedge rstN) begin
    if (!rstN)
      wasOn1 <= 1'b0;
    else if (enVec[1])
      wasOn1 <= 1'b1;
    else if (g_lane[1].peerEnSh[SYNC_STAGES-1])
      wasOn1 <= 1'b0;
  end

  assign enNow     = enVec;
  assign clkOut    = |(clkIn & enVec);
  assign activeSel = enVec[1] | (~enVec[0] & wasOn1);
endmodule

// File: rtl/refsw_miss.sv
`timescale 1ns/1ps
module refsw_miss #(
  parameter int SYNC_STAGES = 2,
  parameter int MISS_LIMIT  = 4
) (
  input  logic watchedClk,
  input  logic watcherClk,
  input  logic rstN,
  output logic missing
);
  localparam int MW = $clog2(MISS_LIMIT + 1);

  logic               togL;
  logic [SYNC_STAGES:0] sh;
  logic [MW-1:0]      cnt;
  logic               quiet;

  always_ff @(posedge watchedClk or negedge rstN) begin
    if (!rstN) togL <= 1'b0;
    else       togL <= ~togL;
  end

  assign quiet = (sh[SYNC_STAGES] == sh[SYNC_STAGES-1]);

  always_ff @(posedge watcherClk or negedge rstN) begin
    if (!rstN) begin
      sh  <= '0;
      cnt <= '0;
    end else begin
      sh <= {sh[SYNC_STAGES-1:0], togL};
      if (!quiet)
        cnt <= '0;
      else if (cnt != MW'(MISS_LIMIT))
        cnt <= cnt + 1'b1;
    end
  end

  assign missing = (cnt == MW'(MISS_LIMIT));

  p_bad_after_quiet_r8: assert property (@(posedge watcherClk) disable iff (!rstN)
    $rose(missing) |-> $past(quiet));
endmodule

// File: rtl/refclk_switch.sv
`timescale 1ns/1ps
module refclk_switch
  import refsw_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 3,
  parameter int MISS_LIMIT  = 4
) (
  input  logic clk0In,
  input  logic clk1In,
  input  logic rstN,
  input  logic switchReq,
  output logic clkOut,
  output logic activeSel,
  output logic bad0,
  output logic bad1
);
  logic [NUM_SRC-1:0] clkVec;
  logic [NUM_SRC-1:0] enNow;
  logic [NUM_SRC-1:0] badVec;
  refsw_strobe_t      strobe;

  assign clkVec = {clk1In, clk0In};

  refsw_ctrl #(.SYNC_STAGES(SYNC_STAGES), .QUAL_CYCLES(QUAL_CYCLES)) ctrl_i (
    .clkIn(clkVec), .rstN(rstN), .switchReq(switchReq),
    .enNow(enNow), .strobe(strobe));

  refsw_gate #(.SYNC_STAGES(SYNC_STAGES)) gate_i (
    .clkIn(clkVec), .rstN(rstN), .strobe(strobe),
    .enNow(enNow), .clkOut(clkOut), .activeSel(activeSel));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_miss
    refsw_miss #(.SYNC_STAGES(SYNC_STAGES), .MISS_LIMIT(MISS_LIMIT)) miss_i (
      .watchedClk(clkVec[i]), .watcherClk(clkVec[1-i]),
      .rstN(rstN), .missing(badVec[i]));
  end

  assign bad0 = badVec[0];
  assign bad1 = badVec[1];
endmodule

// File: tb/refclk_switch_tb_top.sv
`timescale 1ns/1ps
module refclk_switch_tb_top;
  logic clk0 = 1'b0, clk1 = 1'b0, rstN = 1'b0, req = 1'b0, run1 = 1'b1;
  logic clkOut, activeSel, bad0, bad1;
  int   nTests = 0, nFail = 0, edgeCnt = 0, glitchCnt = 0;
  bit   finished = 1'b0;
  real  riseT = 0.0;

  refclk_switch dut_i (.clk0In(clk0), .clk1In(clk1), .rstN(rstN), .switchReq(req),
                       .clkOut(clkOut), .activeSel(activeSel), .bad0(bad0), .bad1(bad1));

  initial forever #2 clk0 = ~clk0;                     // 250 MHz
  initial forever begin #3; clk1 = run1 ? ~clk1 : 1'b0; end

  always @(posedge clkOut) begin edgeCnt++; riseT = $realtime; end
  always @(negedge clkOut) if ($realtime - riseT < 1.5) glitchCnt++;

  localparam int NV = 6;
  localparam int HOLD_NS [NV] = '{40, 5, 40, 7, 40, 400};
  localparam bit EXP_SEL [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

  function automatic string tagFor(int k);
    case (k)
      0: return "R1";
      1, 3: return "R2";
      5: return "R10";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic countEdges(output int n);
    int s;
    s = edgeCnt;
    #240;
    n = edgeCnt - s;
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  initial begin
    #100000;
    nTests++; nFail++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_up();
  end

  initial begin
    int n;
    // R11: reset state
    #20.5;
    chk(clkOut == 1'b0, "R11", "clkOut in reset", int'(clkOut), 0);
    chk(activeSel == 1'b0, "R11", "activeSel in reset", int'(activeSel), 0);
    chk(bad0 == 1'b0 && bad1 == 1'b0, "R11", "bad flags in reset", int'({bad1, bad0}), 0);
    #1 rstN = 1'b1;                 // 21.5
    #1;                             // 22.5: clk0 high, no falling edge yet
    chk(clkOut == 1'b0, "R11", "clkOut before first falling edge", int'(clkOut), 0);
    #4;                             // 26.5: clk0 high after connect at 24
    chk(clkOut == 1'b1, "R11", "clkOut follows clk0", int'(clkOut), 1);
    #100;

    // vector table: hold time and expected selection afterwards
    for (int k = 0; k < NV; k++) begin
      req = 1'b1;
      #(HOLD_NS[k]);
      req = 1'b0;
      #300;
      chk(activeSel == EXP_SEL[k], tagFor(k), "activeSel after request", int'(activeSel), int'(EXP_SEL[k]));
      countEdges(n);
      if (EXP_SEL[k])
        chk(n >= 39 && n <= 41, "R4", "edges of selected clk1", n, 40);
      else
        chk(n >= 59 && n <= 61, "R4", "edges of selected clk0", n, 60);
      chk(bad0 == 1'b0 && bad1 == 1'b0, "R9", "bad flags with both running", int'({bad1, bad0}), 0);
      chk(glitchCnt == 0, "R3", "runt pulses on clkOut", glitchCnt, 0);
    end

    // R7/R8/R5: switch to a stopped clock
    run1 = 1'b0;
    #200;
    chk(bad1 == 1'b1, "R8", "bad1 with clk1 stopped", int'(bad1), 1);
    chk(bad0 == 1'b0, "R8", "bad0 with clk0 running", int'(bad0), 0);
    req = 1'b1; #40; req = 1'b0;
    #200;
    countEdges(n);
    chk(n == 0, "R7", "clkOut gated while target absent", n, 0);
    chk(activeSel == 1'b0, "R5", "activeSel holds while gated", int'(activeSel), 0);
    run1 = 1'b1;
    #300;
    chk(activeSel == 1'b1, "R7", "switch completes once clk1 runs", int'(activeSel), 1);
    chk(bad1 == 1'b0, "R8", "bad1 clears when clk1 returns", int'(bad1), 0);
    countEdges(n);
    chk(n >= 39 && n <= 41, "R7", "edges of clk1 after late connect", n, 40);
    chk(glitchCnt == 0, "R3", "runt pulses after late connect", glitchCnt, 0);

    finish_up();
  end
endmodule